// File: doc/BRIEF.md
# DMA Request Routing and Interrupt Summary Hub

This block is the common front end of a multi-channel DMA controller. Peripherals raise request lines toward it. Software programs one routing register for each request line, and each register names the DMA channel that the line should drive. A line only reaches a channel when the valid bit in its register is set. If several lines are routed to one channel, their requests are ORed into that channel's request output. The channel engines themselves sit outside this block.

The hub also gathers the pending-interrupt flag of every channel into one summary word. Software reads this word and services the set bits, starting from the lowest. One combined interrupt line is high while any bit of the summary word is set. A small register, also held here, has one bit per channel that lets that channel do byte-aligned transfers.

Software uses a plain register port with separate write and read strobes. A read returns its data one cycle after the strobe and marks it with a valid pulse. The port has no back-pressure: an access is never stalled. The request and interrupt pins are plain levels and have no handshake.

Top module: `dreq_route_hub`

## Requirements
- R1: A routing register keeps write-data bit 7 as its valid flag and bits 4:0 as its channel number. It reads back exactly those bits, and every other bit reads as zero.
- R2: The routing register for request line n decodes at byte offset 0x100 + 4*n when n < 64, and at 0x1100 + 4*(n-64) otherwise. Address bits 1:0 are ignored.
- R3: When request line n is high and its register is valid with channel number c < NUM_CHAN, output bit c of the channel request is high one clock edge later.
- R4: A routing register whose valid flag is clear, for example after a write of zero, drives no channel.
- R5: When two or more valid registers name the same channel, that channel's request is the OR of their request lines.
- R6: A valid register whose channel number is NUM_CHAN or higher drives no channel.
- R7: The summary word at offset 0xF0 has bit i set when channel i's interrupt input was high at the previous clock edge. The summary word is read-only.
- R8: The combined interrupt output is the OR of the summary word. It falls one edge after every channel interrupt input has gone low.
- R9: The alignment register at offset 0xA0 holds one bit per channel. It is readable and writable, its bits drive the per-channel alignment outputs, and bits at or above NUM_CHAN are dropped.
- R10: After reset, every routing register is zero, no channel request is high, the combined interrupt is low and every alignment bit is zero.
- R11: A read returns data with a valid pulse one cycle after the read strobe. Offsets that decode to nothing read as zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid when bus_rvalid is high |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| periph_req_i | input | NUM_REQ | Peripheral request lines |
| chan_req_o | output | NUM_CHAN | Routed request for each channel |
| chan_irq_i | input | NUM_CHAN | Pending-interrupt flag from each channel |
| align_o | output | NUM_CHAN | Byte-alignment enable for each channel |
| irq_o | output | 1 | Combined interrupt |

## Verification
Some properties are checked by assertions on every cycle. A write to a routing register or to the alignment register must show up in that register on the next edge. The channel request outputs must go quiet one edge after all request lines are low, or after all mappings are invalid. The summary word and the combined interrupt must track the channel interrupt inputs with one cycle of delay. Each read strobe must produce a valid pulse one cycle later.

The bench scenarios cover what these properties cannot. They check the address of each of the 72 routing registers in both banks, the routing result for every line, the ORing of lines that share a channel, the dropping of out-of-range channel numbers, all 256 interrupt patterns of an eight-channel setup, and the fact that stray writes change nothing.

// File: rtl/dreq_route_pkg.sv
package dreq_route_pkg;
  localparam int DATA_W        = 32;
  localparam int MAP_VALID_BIT = 7;
  localparam int MAP_CHAN_W    = 5;
  localparam int BANK_ENTRIES  = 64;
  localparam int LO_BANK_BASE  = 'h0100;
  localparam int HI_BANK_BASE  = 'h1100;
  localparam int ALIGN_OFS     = 'h00A0;
  localparam int SUMMARY_OFS   = 'h00F0;

  // byte offset of the routing register for request line n
  function automatic int map_offset(input int n);
    int base;
    base = (n < BANK_ENTRIES) ? LO_BANK_BASE : HI_BANK_BASE;
    return base + 4 * (n % BANK_ENTRIES);
  endfunction
endpackage

// File: rtl/dreq_map_regfile.sv
module dreq_map_regfile
  import dreq_route_pkg::*;
#(
  parameter int NUM_REQ = 72,
  parameter int ADDR_W  = 16
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr_en,
  input  logic [ADDR_W-1:0]                    addr,
  input  logic [DATA_W-1:0]                    wdata,
  output logic [NUM_REQ-1:0]                   map_valid,
  output logic [NUM_REQ-1:0][MAP_CHAN_W-1:0]   map_chan,
  output logic                                 map_sel,
  output logic [DATA_W-1:0]                    map_rdata
);
  logic [NUM_REQ-1:0] hit;
  logic unused_addr_lsb;
  assign unused_addr_lsb = ^addr[1:0];

  for (genvar n = 0; n < NUM_REQ; n++) begin : g_entry
    localparam logic [ADDR_W-1:0] OFS_A = ADDR_W'(map_offset(n));
    assign hit[n] = (addr[ADDR_W-1:2] == OFS_A[ADDR_W-1:2]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        map_valid[n] <= 1'b0;
        map_chan[n]  <= '0;
      end else if (wr_en && hit[n]) begin
        map_valid[n] <= wdata[MAP_VALID_BIT];
        map_chan[n]  <= wdata[MAP_CHAN_W-1:0];
      end
    end

    AST_MAP_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && hit[n]) |=> (map_valid[n] == $past(wdata[MAP_VALID_BIT]) &&
                             map_chan[n] == $past(wdata[MAP_CHAN_W-1:0]))); // R1
  end

  assign map_sel = |hit;

  always_comb begin
    map_rdata = '0;
    for (int n = 0; n < NUM_REQ; n++) begin
      if (hit[n]) begin
        map_rdata[MAP_VALID_BIT]    = map_valid[n];
        map_rdata[MAP_CHAN_W-1:0]   = map_chan[n];
      end
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^{wdata[DATA_W-1:MAP_VALID_BIT+1], wdata[MAP_VALID_BIT-1:MAP_CHAN_W]};
endmodule

// File: rtl/dreq_router.sv
module dreq_router
  import dreq_route_pkg::*;
#(
  parameter int NUM_REQ  = 72,
  parameter int NUM_CHAN = 32
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_REQ-1:0]                 req_i,
  input  logic [NUM_REQ-1:0]                 map_valid,
  input  logic [NUM_REQ-1:0][MAP_CHAN_W-1:0] map_chan,
  output logic [NUM_CHAN-1:0]                chan_req_o
);
  logic [NUM_CHAN-1:0] chan_req_d;

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    logic any_req;
    always_comb begin
      any_req = 1'b0;
      for (int r = 0; r < NUM_REQ; r++) begin
        any_req = any_req | (req_i[r] & map_valid[r] &
                             (map_chan[r] == MAP_CHAN_W'(c)));
      end
    end
    assign chan_req_d[c] = any_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chan_req_o <= '0;
    else        chan_req_o <= chan_req_d;
  end

  AST_ROUTE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i == '0) |=> (chan_req_o == '0)); // R3
  AST_INVALID_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (map_valid == '0) |=> (chan_req_o == '0)); // R4
endmodule

// File: rtl/dreq_irq_summary.sv
module dreq_irq_summary #(
  parameter int NUM_CHAN = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_CHAN-1:0] chan_irq_i,
  output logic [NUM_CHAN-1:0] summary_o,
  output logic                irq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) summary_o <= '0;
    else        summary_o <= chan_irq_i;
  end

  assign irq_o = |summary_o;

  AST_SUMMARY_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (summary_o == $past(chan_irq_i))); // R7
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (|chan_irq_i) |=> irq_o); // R8
  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_irq_i == '0) |=> !irq_o); // R8
endmodule

// File: rtl/dreq_route_hub.sv
module dreq_route_hub
  import dreq_route_pkg::*;
#(
  parameter int NUM_REQ  = 72,
  parameter int NUM_CHAN = 32,
  parameter int ADDR_W   = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic                bus_rvalid,
  input  logic [NUM_REQ-1:0]  periph_req_i,
  output logic [NUM_CHAN-1:0] chan_req_o,
  input  logic [NUM_CHAN-1:0] chan_irq_i,
  output logic [NUM_CHAN-1:0] align_o,
  output logic                irq_o
);
  localparam logic [ADDR_W-1:0] ALIGN_A = ADDR_W'(ALIGN_OFS);
  localparam logic [ADDR_W-1:0] SUM_A   = ADDR_W'(SUMMARY_OFS);

  logic [NUM_REQ-1:0]                 map_valid;
  logic [NUM_REQ-1:0][MAP_CHAN_W-1:0] map_chan;
  logic                               map_sel;
  logic [DATA_W-1:0]                  map_rdata;
  logic [NUM_CHAN-1:0]                summary;
  logic                               align_hit;
  logic                               sum_hit;
  logic [DATA_W-1:0]                  rd_mux;

  dreq_map_regfile #(.NUM_REQ(NUM_REQ), .ADDR_W(ADDR_W)) u_maps (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .map_valid(map_valid), .map_chan(map_chan), .map_sel(map_sel), .map_rdata(map_rdata)
  );

  dreq_router #(.NUM_REQ(NUM_REQ), .NUM_CHAN(NUM_CHAN)) u_router (
    .clk(clk), .rst_n(rst_n), .req_i(periph_req_i),
    .map_valid(map_valid), .map_chan(map_chan), .chan_req_o(chan_req_o)
  );

  dreq_irq_summary #(.NUM_CHAN(NUM_CHAN)) u_irq (
    .clk(clk), .rst_n(rst_n), .chan_irq_i(chan_irq_i),
    .summary_o(summary), .irq_o(irq_o)
  );

  assign align_hit = (bus_addr[ADDR_W-1:2] == ALIGN_A[ADDR_W-1:2]);
  assign sum_hit   = (bus_addr[ADDR_W-1:2] == SUM_A[ADDR_W-1:2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  align_o <= '0;
    else if (bus_wr && align_hit) align_o <= bus_wdata[NUM_CHAN-1:0];
  end

  always_comb begin
    if (map_sel)        rd_mux = map_rdata;
    else if (align_hit) rd_mux = DATA_W'(align_o);
    else if (sum_hit)   rd_mux = DATA_W'(summary);
    else                rd_mux = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  AST_ALIGN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && align_hit) |=> (align_o == $past(bus_wdata[NUM_CHAN-1:0]))); // R9
  AST_RVALID_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid); // R11
  AST_NO_SPURIOUS_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid); // R11
endmodule

// File: tb/tb_dreq_route_hub.sv
module tb_dreq_route_hub;
  localparam int NREQ = 72;
  localparam int NCH  = 8;
  localparam int AW   = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic bus_rvalid;
  logic [NREQ-1:0] periph_req = '0;
  logic [NCH-1:0] chan_req, chan_irq = '0, align;
  logic irq;

  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dreq_route_hub #(.NUM_REQ(NREQ), .NUM_CHAN(NCH), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .periph_req_i(periph_req), .chan_req_o(chan_req), .chan_irq_i(chan_irq),
    .align_o(align), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int offs(input int n);
    return (n < 64) ? ('h100 + 4 * n) : ('h1100 + 4 * (n - 64));
  endfunction

  function automatic bit ent_valid(input int n); return (n % 5) != 4; endfunction
  function automatic int ent_chan(input int n); return n % 11; endfunction

  task automatic bus_write(input int a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input int a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = AW'(a);
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
    check("R11 rvalid", 32'(bus_rvalid), 32'd1);
  endtask

  task automatic route(input logic [NREQ-1:0] r, input logic [NCH-1:0] exp, input string req);
    @(negedge clk); periph_req = r;
    @(negedge clk); check(req, 32'(chan_req), 32'(exp));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    logic [NCH-1:0] all_exp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    @(negedge clk);
    check("R10 chan_req", 32'(chan_req), 0);
    check("R10 irq", 32'(irq), 0);
    check("R10 align", 32'(align), 0);
    bus_read(offs(0), rd);  check("R10 map0", rd, 0);
    bus_read(offs(70), rd); check("R10 map70", rd, 0);

    // R1 R2: program all entries with junk bits, then read every one back
    for (int n = 0; n < NREQ; n++)
      bus_write(offs(n), 32'hFFFF_FF60 | (ent_valid(n) ? 32'h80 : 0) | 32'(ent_chan(n)));
    for (int n = 0; n < NREQ; n++) begin
      bus_read(offs(n) + (n % 4), rd);
      check("R1 R2 map readback", rd, (ent_valid(n) ? 32'h80 : 0) | 32'(ent_chan(n)));
    end

    // R3 R4 R6: single-line routing sweep
    all_exp = '0;
    for (int n = 0; n < NREQ; n++) begin
      logic [NCH-1:0] e;
      e = (ent_valid(n) && ent_chan(n) < NCH) ? NCH'(1 << ent_chan(n)) : '0;
      all_exp |= e;
      route(NREQ'(1) << n, e, "R3 R4 R6 single route");
    end
    route('1, all_exp, "R5 all lines");

    // R5: two lines on one channel
    bus_write(offs(3), 32'h83);
    bus_write(offs(5), 32'h83);
    route((NREQ'(1) << 3) | (NREQ'(1) << 5), 8'h08, "R5 shared both");
    route(NREQ'(1) << 5, 8'h08, "R5 shared one");
    route('0, 8'h00, "R3 idle");

    // R4: write zero removes routing
    bus_write(offs(12), 32'h0);
    route(NREQ'(1) << 12, 8'h00, "R4 cleared map");
    bus_read(offs(12), rd); check("R4 cleared readback", rd, 0);

    // R6: channel number beyond NUM_CHAN
    bus_write(offs(66), 32'h80 | 32'd20);
    route(NREQ'(1) << 66, 8'h00, "R6 out-of-range chan");
    bus_write(offs(66), 32'h80 | 32'd7);
    route(NREQ'(1) << 66, 8'h80, "R3 upper bank route");

    // R11: undecoded offsets
    bus_write('h1100 + 4 * 8, 32'h81);
    bus_read('h1100 + 4 * 8, rd); check("R11 hole read", rd, 0);
    bus_read(offs(8), rd); check("R11 no alias", rd, 32'h88);
    bus_read('h300, rd); check("R11 unmapped read", rd, 0);
    bus_write('hF0, 32'hFF);
    bus_read('hF0, rd); check("R7 summary read-only", rd, 0);
    check("R8 irq after summary write", 32'(irq), 0);

    // R9: alignment register
    bus_write('hA0, 32'hA5);
    @(negedge clk); check("R9 align out", 32'(align), 32'hA5);
    bus_read('hA0, rd); check("R9 align readback", rd, 32'hA5);
    bus_write('hA0, 32'hFFFF_FF5A);
    bus_read('hA0, rd); check("R9 align masked", rd, 32'h5A);

    // R7 R8: every interrupt pattern
    for (int v = 0; v < 256; v++) begin
      @(negedge clk); chan_irq = NCH'(v);
      @(negedge clk); check("R8 irq level", 32'(irq), 32'(v != 0));
      bus_read('hF0, rd); check("R7 summary", rd, 32'(v));
    end
    @(negedge clk); chan_irq = '0;
    @(negedge clk); check("R8 irq drops", 32'(irq), 0);

    finish_run();
  end
endmodule